// File: doc/BRIEF.md
# SD card clock divider

This block derives the card-side clock of an SD host from the host clock. The divisor is a power of two from 1 to 1024. Software picks it through a single control word whose divisor field has a mixed encoding. Bits 0 to 7 are one-hot selects for the ratios 4 up to 512. An all-zero field means divide-by-2. Two outlying bits pick pass-through (ratio 1) and ratio 1024. The same word holds a clock-output enable and an auto-stop flag. With auto-stop set, the card clock stops while the host reports that it has nothing in flight.

Every start, stop and change of rate happens at a period boundary, while the divided clock is low. No high or low phase is ever cut short. Software can therefore turn the output off, load a new ratio and turn it back on without producing a runt pulse. Alongside the card clock the block produces a one-host-cycle strobe for each card clock rising edge. Logic in the host clock domain uses that strobe in place of the card clock edge.

Top module: `sdclk_divider`

## Requirements
- R1: While reset is asserted and after its release, until a write enables the clock, the card clock is low and the strobe is low.
- R2: With only divisor bit i set (i = 0..7), the card clock period is 2^(i+2) host cycles and the clock is high for exactly half of each period.
- R3: With none of bits 0..7, 10 and 16 set, the card clock period is 2 host cycles, high for 1.
- R4: Bit 10 selects pass-through: the card clock follows the host clock, one pulse per host cycle, whatever other divisor bits are set.
- R5: Bit 16 alone selects a period of 1024 cycles when parameter HAS_DIV1024 is 1. When HAS_DIV1024 is 0, the same bit selects a period of 512.
- R6: When several divisor bits are set and bit 10 is clear, the lowest set bit among bits 0..7 decides the ratio, and bit 16 only counts when bits 0..7 are all clear.
- R7: Bit 8 enables the card clock. Cleared while the clock is high, the current high phase and the low phase after it complete at full length; the clock then stays low with no strobe.
- R8: Bit 9 (auto-stop) parks the clock low at the next period boundary while host_busy is low. The clock runs while host_busy is high. With bit 9 clear, host_busy has no effect.
- R9: sd_clk_stb is high for exactly one host cycle per card clock period, in the host cycle in which sd_clk rises (in pass-through, every cycle that carries a pulse).
- R10: A new divisor written while the clock runs takes effect at the next rising edge. The high phase in progress and the following low phase keep the old half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | REG_W | Control word: divisor bits 0..7, 10, 16; enable bit 8; auto-stop bit 9 |
| host_busy | input | 1 | High while the host has card traffic pending |
| sd_clk | output | 1 | Card clock |
| sd_clk_stb | output | 1 | One-cycle strobe marking each card clock rising edge |

## Verification
A control write lands on the clock edge that follows it. The divided clock and its strobe are registered. A rise or fall decided at an edge is therefore visible in the host cycle that begins at that edge. A start from the parked state begins with a rising edge one edge after the write. The checks do not depend on start-up latency. Periods are measured from strobe to strobe. High time is counted from samples taken 2 ns after each rising host edge, when both the registered clock and the pass-through gate are stable. Boundary cases (stopping, auto-stop, a rate change while the clock is high) are timed from a detected strobe. The phase lengths that follow are counted against the half-periods given in R7 and R10.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int LOG_MAX    = 10;           // largest ratio is 2**LOG_MAX
    localparam int SEL_W      = 4;            // holds log2 ratio 0..LOG_MAX
    localparam int CNT_W      = LOG_MAX - 1;  // half-period counter width
    localparam int ONEHOT_N   = 8;            // one-hot ratio bits
    localparam int POS_ONEHOT = 0;
    localparam int POS_RUN    = 8;
    localparam int POS_AUTO   = 9;
    localparam int POS_BYPASS = 10;
    localparam int POS_D1024  = 16;
    localparam int RESET_SEL  = LOG_MAX - 1;  // divide-by-512 after reset

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic run;
        logic auto_stop;
        sel_t sel;
    } ctrl_t;

    typedef struct packed {
        logic clk;
        logic stb;
        logic run1;
        sel_t sel_act;
        cnt_t cnt;
    } core_t;

    // last counter value of a half period for ratio 2**k (k >= 1)
    function automatic cnt_t half_last(sel_t k);
        int unsigned half;
        half = (32'd1 << k) >> 1;
        if (half == 0) return '0;
        return cnt_t'(half - 1);
    endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter bit HAS_DIV1024 = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             run_en,
    output logic             auto_stop,
    output sel_t             sel
);

    ctrl_t ctrl_d, ctrl_q;

    function automatic sel_t decode_sel(logic [REG_W-1:0] w);
        sel_t s;
        if (w[POS_BYPASS]) begin
            s = '0;
        end else begin
            s = sel_t'(1);
            if (w[POS_D1024])
                s = HAS_DIV1024 ? sel_t'(LOG_MAX) : sel_t'(LOG_MAX - 1);
            for (int i = ONEHOT_N - 1; i >= 0; i--)
                if (w[POS_ONEHOT + i]) s = sel_t'(i + 2);
        end
        return s;
    endfunction

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.run       = wr_data[POS_RUN];
            ctrl_d.auto_stop = wr_data[POS_AUTO];
            ctrl_d.sel       = decode_sel(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.run       <= 1'b0;
            ctrl_q.auto_stop <= 1'b0;
            ctrl_q.sel       <= sel_t'(RESET_SEL);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign run_en    = ctrl_q.run;
    assign auto_stop = ctrl_q.auto_stop;
    assign sel       = ctrl_q.sel;

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.sel <= sel_t'(LOG_MAX)); // R5

    if (!HAS_DIV1024) begin : g_no_1024
        AST_NO_DIV1024: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_q.sel != sel_t'(LOG_MAX)); // R5
    end

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
    import sdclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  sel_t sel_pend,
    output logic clk_div,
    output logic rise_stb,
    output logic fast_run
);

    core_t core_d, core_q;
    cnt_t  last;
    logic  at_end;

    always_comb begin
        core_d     = core_q;
        core_d.stb = 1'b0;
        last       = half_last(core_q.sel_act);
        at_end     = (core_q.cnt >= last);

        if (core_q.sel_act == '0) begin
            // pass-through: divided clock idle, pulses come from the gate
            core_d.clk     = 1'b0;
            core_d.cnt     = '0;
            core_d.sel_act = sel_pend;
            core_d.run1    = (sel_pend == '0) && run_req;
            core_d.stb     = core_q.run1;
        end else begin
            core_d.run1 = 1'b0;
            if (core_q.clk) begin
                if (at_end) begin
                    core_d.clk = 1'b0;
                    core_d.cnt = '0;
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end else if (at_end) begin
                // period boundary: only place rate and run state change
                core_d.sel_act = sel_pend;
                if (sel_pend == '0) begin
                    core_d.run1 = run_req;
                end else if (run_req) begin
                    core_d.clk = 1'b1;
                    core_d.cnt = '0;
                    core_d.stb = 1'b1;
                end
            end else begin
                core_d.cnt = core_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.clk     <= 1'b0;
            core_q.stb     <= 1'b0;
            core_q.run1    <= 1'b0;
            core_q.sel_act <= sel_t'(RESET_SEL);
            core_q.cnt     <= '1;
        end else begin
            core_q <= core_d;
        end
    end

    assign clk_div  = core_q.clk;
    assign rise_stb = core_q.stb;
    assign fast_run = core_q.run1;

    AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_req && !core_q.clk) |=> !core_q.clk); // R7

    AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_q.clk) && core_q.sel_act >= sel_t'(2)) |=> core_q.clk); // R2

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.clk |=> $stable(core_q.sel_act)); // R10

    AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.stb && !$past(core_q.run1)) |-> (core_q.clk && !$past(core_q.clk))); // R9

endmodule

// File: rtl/sdclk_fast_gate.sv
module sdclk_fast_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_run,
    input  logic clk_div,
    output logic sd_clk
);

    logic gate_d, gate_q;

    always_comb begin
        gate_d = fast_run;
    end

    // updated while clk is low so the AND below never truncates a pulse
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign sd_clk = (clk & gate_q) | clk_div;

    AST_GATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> !clk_div); // R4

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter bit HAS_DIV1024 = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             host_busy,
    output logic             sd_clk,
    output logic             sd_clk_stb
);

    logic run_en;
    logic auto_stop;
    sel_t sel;
    logic run_req;
    logic clk_div;
    logic fast_run;

    sdclk_ctrl_reg #(
        .REG_W      (REG_W),
        .HAS_DIV1024(HAS_DIV1024)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_data  (cfg_wdata),
        .run_en   (run_en),
        .auto_stop(auto_stop),
        .sel      (sel)
    );

    assign run_req = run_en && !(auto_stop && !host_busy);

    sdclk_div_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (run_req),
        .sel_pend(sel),
        .clk_div (clk_div),
        .rise_stb(sd_clk_stb),
        .fast_run(fast_run)
    );

    sdclk_fast_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_run(fast_run),
        .clk_div (clk_div),
        .sd_clk  (sd_clk)
    );

endmodule

// File: tb/sdclk_divider_tb.sv
module sdclk_divider_tb;

    localparam logic [31:0] EN    = 32'h0000_0100;
    localparam logic [31:0] AUTO  = 32'h0000_0200;
    localparam logic [31:0] BYP   = 32'h0000_0400;
    localparam logic [31:0] D1024 = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, wr2 = 1'b0;
    logic [31:0] wdata = '0, wdata2 = '0;
    logic        busy = 1'b0;
    logic        sd_clk, stb, sd_clk2, stb2;

    always #4 clk = ~clk; // 125 MHz

    sdclk_divider u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_wdata(wdata),
        .host_busy(busy), .sd_clk(sd_clk), .sd_clk_stb(stb)
    );

    sdclk_divider #(.HAS_DIV1024(1'b0)) u_dut_nd (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr2), .cfg_wdata(wdata2),
        .host_busy(busy), .sd_clk(sd_clk2), .sd_clk_stb(stb2)
    );

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        string req;
        int    period;
    } exp_t;
    exp_t sb_q[$];

    bit have_prev = 1'b0;
    int cyc = 0, prev_cyc = 0, hi_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // monitor: measures each period between strobes and pops expectations
    initial begin
        exp_t e;
        int   eh;
        forever begin
            @(posedge clk); #2;
            if (rst_n) begin
                cyc++;
                if (stb === 1'b1) begin
                    chk(sd_clk === 1'b1, "R9", int'(sd_clk), 1);
                    if (have_prev && sb_q.size() > 0) begin
                        e  = sb_q.pop_front();
                        eh = (e.period == 1) ? 1 : e.period / 2;
                        chk(cyc - prev_cyc == e.period, e.req, cyc - prev_cyc, e.period);
                        chk(hi_cnt == eh, e.req, hi_cnt, eh);
                    end
                    have_prev = 1'b1;
                    prev_cyc  = cyc;
                    hi_cnt    = 0;
                end
                if (sd_clk === 1'b1) hi_cnt++;
            end
        end
    end

    task automatic wr_ctrl(input logic [31:0] w);
        @(negedge clk); wr = 1'b1; wdata = w;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic park();
        wr_ctrl(32'h0);
        repeat (1100) @(negedge clk);
        have_prev = 1'b0;
    endtask

    // driver: park, queue the expected periods, then start the clock
    task automatic run_div(input string req, input logic [31:0] w, input int period, input int n);
        exp_t e;
        park();
        for (int i = 0; i < n; i++) begin
            e.req = req; e.period = period;
            sb_q.push_back(e);
        end
        wr_ctrl(w);
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    task automatic wait_stb();
        do begin @(posedge clk); #2; end while (stb !== 1'b1);
    endtask

    // called right after a strobe sample: writes w while the clock is high
    task automatic change_on_high(input logic [31:0] w, output int hi, output int lo,
                                  output int hi2, output int stbs);
        hi = 1; lo = 0; hi2 = 0; stbs = 0;
        @(negedge clk); wr = 1'b1; wdata = w;
        @(posedge clk); #1 wr = 1'b0; #1;
        while (sd_clk === 1'b1 && hi < 600) begin
            if (stb === 1'b1) stbs++;
            hi++; @(posedge clk); #2;
        end
        while (sd_clk === 1'b0 && lo < 200) begin
            if (stb === 1'b1) stbs++;
            lo++; @(posedge clk); #2;
        end
        while (sd_clk === 1'b1 && hi2 < 600) begin
            if (stb === 1'b1) stbs++;
            hi2++; @(posedge clk); #2;
        end
    endtask

    task automatic quiet_window(input string req, input int n);
        int seen_stb = 0, seen_hi = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            if (stb === 1'b1) seen_stb++;
            if (sd_clk === 1'b1) seen_hi++;
        end
        chk(seen_stb == 0, req, seen_stb, 0);
        chk(seen_hi == 0, req, seen_hi, 0);
    endtask

    initial begin
        int hi, lo, hi2, stbs, t0;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2 chk(sd_clk === 1'b0 && stb === 1'b0, "R1", int'(sd_clk), 0);
        @(negedge clk); rst_n = 1'b1;
        quiet_window("R1", 20);

        // R2: each one-hot divisor bit
        for (int i = 0; i < 8; i++)
            run_div("R2", 32'(1) << i | EN, 4 << i, 3);

        // R3: empty field is divide-by-2
        run_div("R3", EN, 2, 4);

        // R4: pass-through, also overriding other bits
        run_div("R4", BYP | EN, 1, 5);
        run_div("R4", BYP | 32'h8 | D1024 | EN, 1, 5);

        // R5: divide-by-1024, and 512 when the option is absent
        run_div("R5", D1024 | EN, 1024, 2);
        @(negedge clk); wr2 = 1'b1; wdata2 = D1024 | EN;
        @(negedge clk); wr2 = 1'b0;
        do begin @(posedge clk); #2; end while (stb2 !== 1'b1);
        t0 = 0;
        do begin @(posedge clk); #2; t0++; end while (stb2 !== 1'b1 && t0 < 2000);
        chk(t0 == 512, "R5", t0, 512);

        // R6: lowest one-hot bit wins, bit 16 loses to it
        run_div("R6", 32'h28 | D1024 | EN, 32, 3);
        run_div("R6", 32'hC0 | EN, 256, 3);

        // R7: disable while high finishes the pulse, then stays low
        park();
        wr_ctrl(32'h2 | EN);
        wait_stb();
        change_on_high(32'h2, hi, lo, hi2, stbs);
        chk(hi == 4, "R7", hi, 4);
        chk(lo == 200, "R7", lo, 200);
        chk(stbs == 0, "R7", stbs, 0);

        // R10: rate change while high keeps the old half-periods once
        park();
        wr_ctrl(32'h2 | EN);
        wait_stb();
        change_on_high(32'h8 | EN, hi, lo, hi2, stbs);
        chk(hi == 4, "R10", hi, 4);
        chk(lo == 4, "R10", lo, 4);
        chk(hi2 == 16, "R10", hi2, 16);

        // R8: auto-stop with host_busy
        park();
        busy = 1'b0;
        wr_ctrl(32'h1 | EN | AUTO);
        quiet_window("R8", 40);
        have_prev = 1'b0;
        for (int i = 0; i < 3; i++) sb_q.push_back('{req: "R8", period: 4});
        @(negedge clk); busy = 1'b1;
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk); busy = 1'b0;
        repeat (8) @(negedge clk);
        quiet_window("R8", 40);
        park();
        for (int i = 0; i < 3; i++) sb_q.push_back('{req: "R8", period: 4});
        wr_ctrl(32'h1 | EN);
        while (sb_q.size() > 0) @(negedge clk);

        chk(sb_q.size() == 0, "R9", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule